// File: doc/BRIEF.md
# Transmit Credit Tracker for a Multiplexed Serial Link

This block runs on the host side of a link that carries data for four serial ports over one shared pipe. The peripheral reports how much buffer space each port has left by sending a short flow-control status packet. The packet arrives one byte at a time. The tracker rebuilds that packet from the byte stream. It keeps the receive-bytes-available count and one transmit credit per port.

Before a data record goes out, the host asks the tracker whether the record may be sent, giving the port number and the record length. The tracker grants the request only if the port has been opened, has had its credit reported since the open, and has enough credit left. It also checks that the length is within the largest record the link allows. Each grant takes the record length off that port's credit. A denied request changes nothing. If the byte stream is cut off part way through a packet, the host can abort, and the partial packet is dropped.

Top module: `tx_credit_tracker`

## Requirements
- R1: After reset, every port credit and the receive-available count read zero, and `rsp_valid` is low.
- R2: A status packet is 10 accepted bytes, laid out as five 16-bit fields, each sent low byte first. Field 0 is the receive-available count and fields 1 to 4 are the credits of ports 0 to 3. The cycle after the tenth byte is accepted, `rx_avail` and the credits show the new values.
- R3: A port that has never been opened keeps a credit of zero whatever packets arrive, and every request to it is denied.
- R4: A pulse on `open_valid` sets the credit of `open_port` to zero. Requests to that port are then denied until a packet has completed after the open.
- R5: A request is answered one cycle later with `rsp_valid` high for exactly one cycle. `rsp_grant` is high only if the port is live, the length is at most its credit, and the length is at most 4095.
- R6: A granted request lowers the port's credit by the request length, and the new value is visible in the same cycle as the response.
- R7: A denied request leaves every credit and `rx_avail` unchanged.
- R8: A length above 4095 is denied even when the port's credit is larger.
- R9: When a granted request and the tenth packet byte fall in the same cycle, the grant is judged on the credit held before the packet. The credit then takes the packet value, with nothing subtracted.
- R10: `st_abort` drops any partly received packet, and the next accepted byte starts a new packet. A byte presented in the same cycle as the abort is dropped as well.
- R11: An open that falls in the same cycle as the tenth packet byte takes priority. That port ends at zero credit and is still not live, while the other open ports load normally.
- R12: Cycles with `st_valid` low are ignored. Packet bytes may be separated by any number of idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Status byte present this cycle |
| st_byte | input | 8 | Status packet byte |
| st_abort | input | 1 | Drop any partly received packet |
| open_valid | input | 1 | A port is being opened this cycle |
| open_port | input | 2 | Port being opened |
| req_valid | input | 1 | Send request present |
| req_port | input | 2 | Target port of the request |
| req_len | input | 16 | Record length in bytes |
| rsp_valid | output | 1 | Response to the previous cycle's request |
| rsp_grant | output | 1 | 1 = granted, 0 = denied |
| rx_avail | output | 16 | Last reported receive-available count |
| credit_flat | output | 64 | Port credits, port p at bits [16p+15:16p] |

## Verification
Three pairs of events can land on the same clock edge: a send request and the completion of a status packet, an open and a packet completion, and an abort and an incoming byte. The bench feeds nine packet bytes and then presents the tenth byte together with a request, or together with an open, in the same drive window. It checks the request response against the credit that was held before the packet, and checks the final credit against the packet value, or against zero for the port that was just opened. For the abort case it presents an abort and a junk byte together, then sends a complete packet and checks that every field loads exactly.

// File: rtl/credit_pkg.sv
package credit_pkg;
  typedef enum logic [1:0] {
    PS_CLOSED = 2'd0,
    PS_WAIT   = 2'd1,
    PS_LIVE   = 2'd2
  } port_state_e;
endpackage

// File: rtl/cr_status_parser.sv
module cr_status_parser #(
  parameter int NUM_PORTS = 4,
  parameter int CNT_W     = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              byte_valid,
  input  logic [7:0]                        byte_data,
  input  logic                              abort,
  output logic                              pkt_done,
  output logic [(NUM_PORTS+1)*CNT_W-1:0]    pkt_fields
);
  localparam int BYTES_PER_FIELD = CNT_W / 8;
  localparam int NUM_FIELDS      = NUM_PORTS + 1;
  localparam int PKT_BYTES       = NUM_FIELDS * BYTES_PER_FIELD;
  localparam int IDX_W           = $clog2(PKT_BYTES);

  logic [IDX_W-1:0] idx_q;
  logic [7:0]       hold_q [PKT_BYTES-1];
  logic             take;
  logic             last;

  assign take     = byte_valid && !abort;
  assign last     = (idx_q == IDX_W'(PKT_BYTES - 1));
  assign pkt_done = take && last;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      idx_q <= '0;
    end else if (take) begin
      idx_q <= last ? '0 : idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (take && !last) begin
      hold_q[idx_q] <= byte_data;
    end
  end

  // Fields are little-endian and in order, so byte b sits at bit 8*b.
  for (genvar b = 0; b < PKT_BYTES - 1; b++) begin : g_hold
    assign pkt_fields[b*8 +: 8] = hold_q[b];
  end
  assign pkt_fields[(PKT_BYTES-1)*8 +: 8] = byte_data;

  a_r10_abort_restarts: assert property (@(posedge clk) disable iff (rst)
    abort |=> idx_q == '0);
  a_r2_index_bound: assert property (@(posedge clk) disable iff (rst)
    idx_q < IDX_W'(PKT_BYTES));
  a_r12_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !byte_valid && !abort |=> $stable(idx_q));
endmodule

// File: rtl/cr_port_slot.sv
module cr_port_slot
  import credit_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_hit,
  input  logic             load_hit,
  input  logic [CNT_W-1:0] load_val,
  input  logic             take_hit,
  input  logic [LEN_W-1:0] take_len,
  output logic [CNT_W-1:0] credit_q,
  output logic             live
);
  port_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= PS_CLOSED;
      credit_q <= '0;
    end else if (open_hit) begin
      state_q  <= PS_WAIT;
      credit_q <= '0;
    end else if (load_hit && state_q != PS_CLOSED) begin
      state_q  <= PS_LIVE;
      credit_q <= load_val;
    end else if (take_hit) begin
      credit_q <= credit_q - CNT_W'(take_len);
    end
  end

  assign live = (state_q == PS_LIVE);

  a_r4_not_live_zero: assert property (@(posedge clk) disable iff (rst)
    !live |-> credit_q == '0);
  a_r11_open_clears: assert property (@(posedge clk) disable iff (rst)
    open_hit |=> credit_q == '0 && !live);
  a_r9_packet_wins: assert property (@(posedge clk) disable iff (rst)
    load_hit && live && !open_hit |=> credit_q == $past(load_val));
  a_r6_take_lowers: assert property (@(posedge clk) disable iff (rst)
    take_hit && !load_hit && !open_hit |=> credit_q <= $past(credit_q));
endmodule

// File: rtl/cr_grant_gate.sv
module cr_grant_gate #(
  parameter int NUM_PORTS = 4,
  parameter int CNT_W     = 16,
  parameter int LEN_W     = 16,
  parameter int MAX_LEN   = 4095
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req_valid,
  input  logic [$clog2(NUM_PORTS)-1:0] req_port,
  input  logic [LEN_W-1:0]             req_len,
  input  logic [NUM_PORTS*CNT_W-1:0]   credit_flat,
  input  logic [NUM_PORTS-1:0]         live_vec,
  output logic [NUM_PORTS-1:0]         take_vec,
  output logic                         rsp_valid,
  output logic                         rsp_grant
);
  localparam int PORT_W = $clog2(NUM_PORTS);
  localparam int CMP_W  = (LEN_W > CNT_W) ? LEN_W : CNT_W;

  logic within_cap;
  assign within_cap = (CMP_W'(req_len) <= CMP_W'(MAX_LEN));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_fit
    logic hit;
    logic fits;
    assign hit  = req_valid && (req_port == PORT_W'(p));
    assign fits = live_vec[p] && within_cap &&
                  (CMP_W'(req_len) <= CMP_W'(credit_flat[p*CNT_W +: CNT_W]));
    assign take_vec[p] = hit && fits;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_grant <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_grant <= |take_vec;
    end
  end

  a_r5_answer_next: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r5_grant_needs_valid: assert property (@(posedge clk) disable iff (rst)
    rsp_grant |-> rsp_valid);
  a_r8_cap_denies: assert property (@(posedge clk) disable iff (rst)
    req_valid && (CMP_W'(req_len) > CMP_W'(MAX_LEN)) |=> !rsp_grant);
  a_r4_idle_port_denies: assert property (@(posedge clk) disable iff (rst)
    req_valid && !live_vec[req_port] |=> !rsp_grant);
endmodule

// File: rtl/tx_credit_tracker.sv
module tx_credit_tracker #(
  parameter int NUM_PORTS = 4,
  parameter int CNT_W     = 16,
  parameter int LEN_W     = 16,
  parameter int MAX_LEN   = 4095
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         st_valid,
  input  logic [7:0]                   st_byte,
  input  logic                         st_abort,
  input  logic                         open_valid,
  input  logic [$clog2(NUM_PORTS)-1:0] open_port,
  input  logic                         req_valid,
  input  logic [$clog2(NUM_PORTS)-1:0] req_port,
  input  logic [LEN_W-1:0]             req_len,
  output logic                         rsp_valid,
  output logic                         rsp_grant,
  output logic [CNT_W-1:0]             rx_avail,
  output logic [NUM_PORTS*CNT_W-1:0]   credit_flat
);
  localparam int PORT_W     = $clog2(NUM_PORTS);
  localparam int NUM_FIELDS = NUM_PORTS + 1;

  logic                        pkt_done;
  logic [NUM_FIELDS*CNT_W-1:0] pkt_fields;
  logic [NUM_PORTS-1:0]        live_vec;
  logic [NUM_PORTS-1:0]        take_vec;

  cr_status_parser #(.NUM_PORTS(NUM_PORTS), .CNT_W(CNT_W)) u_parse (
    .clk        (clk),
    .rst        (rst),
    .byte_valid (st_valid),
    .byte_data  (st_byte),
    .abort      (st_abort),
    .pkt_done   (pkt_done),
    .pkt_fields (pkt_fields)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_avail <= '0;
    end else if (pkt_done) begin
      rx_avail <= pkt_fields[0 +: CNT_W];
    end
  end

  cr_grant_gate #(
    .NUM_PORTS(NUM_PORTS), .CNT_W(CNT_W), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN)
  ) u_gate (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_port    (req_port),
    .req_len     (req_len),
    .credit_flat (credit_flat),
    .live_vec    (live_vec),
    .take_vec    (take_vec),
    .rsp_valid   (rsp_valid),
    .rsp_grant   (rsp_grant)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    cr_port_slot #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .open_hit (open_valid && (open_port == PORT_W'(p))),
      .load_hit (pkt_done),
      .load_val (pkt_fields[(p+1)*CNT_W +: CNT_W]),
      .take_hit (take_vec[p]),
      .take_len (req_len),
      .credit_q (credit_flat[p*CNT_W +: CNT_W]),
      .live     (live_vec[p])
    );
  end

  a_r7_deny_keeps_counts: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_grant && !$past(pkt_done) && !$past(open_valid)
      |-> credit_flat == $past(credit_flat) && rx_avail == $past(rx_avail));
  a_r2_rx_only_on_packet: assert property (@(posedge clk) disable iff (rst)
    !pkt_done |=> $stable(rx_avail));
endmodule

// File: tb/sim_tx_credit_tracker.sv
module sim_tx_credit_tracker;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        st_valid, st_abort, open_valid, req_valid;
  logic [7:0]  st_byte;
  logic [1:0]  open_port, req_port;
  logic [15:0] req_len;
  logic        rsp_valid, rsp_grant;
  logic [15:0] rx_avail;
  logic [63:0] credit_flat;

  int checks = 0;
  int errors = 0;

  logic [15:0] exp_cr [4];
  logic        exp_open [4];
  logic        exp_live [4];
  logic [15:0] exp_rx;

  always #(CLK_P/2) clk = ~clk;

  tx_credit_tracker u0 (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_byte(st_byte),
    .st_abort(st_abort), .open_valid(open_valid), .open_port(open_port),
    .req_valid(req_valid), .req_port(req_port), .req_len(req_len),
    .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rx_avail(rx_avail),
    .credit_flat(credit_flat)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    for (int p = 0; p < 4; p++) chk(tag, credit_flat[p*16 +: 16], exp_cr[p]);
    chk(tag, rx_avail, exp_rx);
  endtask

  function automatic logic model_grant(input int p, input logic [15:0] len);
    return exp_live[p] && (len <= exp_cr[p]) && (len <= 16'd4095);
  endfunction

  task automatic model_load(input logic [15:0] rx, input logic [15:0] c [4]);
    exp_rx = rx;
    for (int p = 0; p < 4; p++)
      if (exp_open[p]) begin exp_cr[p] = c[p]; exp_live[p] = 1'b1; end
  endtask

  task automatic push(input logic [7:0] b, input int gap);
    st_valid = 1'b1; st_byte = b;
    tick();
    st_valid = 1'b0;
    repeat (gap) tick();
  endtask

  // Sends the first nine bytes; the tenth byte is the high byte of port 3.
  task automatic push_nine(input logic [15:0] rx, input logic [15:0] c [4], input int gap);
    push(rx[7:0], gap); push(rx[15:8], gap);
    for (int p = 0; p < 3; p++) begin push(c[p][7:0], gap); push(c[p][15:8], gap); end
    push(c[3][7:0], gap);
  endtask

  task automatic send_pkt(input logic [15:0] rx, input logic [15:0] c [4], input int gap);
    push_nine(rx, c, gap);
    push(c[3][15:8], 0);
    model_load(rx, c);
  endtask

  task automatic do_open(input int p);
    open_valid = 1'b1; open_port = 2'(p);
    tick();
    open_valid = 1'b0;
    exp_open[p] = 1'b1; exp_live[p] = 1'b0; exp_cr[p] = '0;
  endtask

  task automatic do_req(input int p, input logic [15:0] len, input string tag);
    logic g;
    g = model_grant(p, len);
    req_valid = 1'b1; req_port = 2'(p); req_len = len;
    tick();
    req_valid = 1'b0;
    if (g) exp_cr[p] = exp_cr[p] - len;
    chk(tag, 16'(rsp_valid), 16'd1);
    chk(tag, 16'(rsp_grant), 16'(g));
    chk_all(tag);
    tick();
    chk(tag, 16'(rsp_valid), 16'd0);
  endtask

  task automatic t_reset();
    chk("R1", 16'(rsp_valid), 16'd0);
    chk_all("R1");
  endtask

  task automatic t_before_open();
    logic [15:0] c [4] = '{16'h0111, 16'h0222, 16'h0333, 16'h0444};
    send_pkt(16'h0A0B, c, 0);
    chk_all("R3");
    chk("R2", rx_avail, 16'h0A0B);
    do_req(0, 16'd1, "R3");
  endtask

  task automatic t_open_and_load();
    logic [15:0] c [4] = '{16'h0100, 16'h0200, 16'h0ABC, 16'h0F00};
    do_open(0); do_open(1); do_open(2);
    do_req(1, 16'd0, "R4");
    send_pkt(16'h1234, c, 0);
    chk_all("R2");
    chk("R3", credit_flat[63:48], 16'h0000);
  endtask

  task automatic t_grants();
    do_req(0, 16'h0040, "R6");
    do_req(0, 16'h00C0, "R6");
    chk("R6", credit_flat[15:0], 16'h0000);
    do_req(0, 16'd1, "R7");
    do_req(3, 16'd1, "R3");
    do_req(2, 16'h0ABD, "R7");
    do_req(2, 16'h0ABC, "R5");
  endtask

  task automatic t_gaps_and_cap();
    logic [15:0] c [4] = '{16'h0010, 16'hFFFF, 16'h1000, 16'h7777};
    send_pkt(16'hBEEF, c, 2);
    chk_all("R12");
    do_req(1, 16'd4096, "R8");
    do_req(1, 16'd4095, "R8");
    chk("R8", credit_flat[31:16], 16'hF000);
    do_req(2, 16'd4096, "R8");
  endtask

  task automatic t_abort();
    logic [15:0] c [4] = '{16'h0300, 16'h0400, 16'h0500, 16'h0600};
    push(8'h77, 0); push(8'h66, 1); push(8'h55, 0); push(8'h44, 0);
    st_abort = 1'b1; tick(); st_abort = 1'b0;
    st_abort = 1'b1; st_valid = 1'b1; st_byte = 8'h99; tick();
    st_abort = 1'b0; st_valid = 1'b0;
    chk_all("R10");
    send_pkt(16'h5555, c, 0);
    chk_all("R10");
  endtask

  task automatic t_collide_request();
    logic [15:0] c [4] = '{16'h0020, 16'h0030, 16'h0040, 16'h0050};
    logic [15:0] d [4] = '{16'h0800, 16'h0030, 16'h0040, 16'h0050};
    logic g;
    push_nine(16'h0001, c, 0);
    g = model_grant(0, 16'h0100);
    st_valid = 1'b1; st_byte = c[3][15:8];
    req_valid = 1'b1; req_port = 2'd0; req_len = 16'h0100;
    tick();
    st_valid = 1'b0; req_valid = 1'b0;
    model_load(16'h0001, c);
    chk("R9", 16'(rsp_grant), 16'(g));
    chk("R9", 16'(g), 16'd1);
    chk_all("R9");
    tick();
    push_nine(16'h0001, d, 0);
    g = model_grant(0, 16'h0700);
    st_valid = 1'b1; st_byte = d[3][15:8];
    req_valid = 1'b1; req_port = 2'd0; req_len = 16'h0700;
    tick();
    st_valid = 1'b0; req_valid = 1'b0;
    model_load(16'h0001, d);
    chk("R9", 16'(rsp_grant), 16'(g));
    chk_all("R9");
    tick();
  endtask

  task automatic t_collide_open();
    logic [15:0] c [4] = '{16'h0101, 16'h0202, 16'h0303, 16'h0404};
    push_nine(16'h0002, c, 0);
    st_valid = 1'b1; st_byte = c[3][15:8];
    open_valid = 1'b1; open_port = 2'd2;
    tick();
    st_valid = 1'b0; open_valid = 1'b0;
    model_load(16'h0002, c);
    exp_live[2] = 1'b0; exp_cr[2] = '0;
    chk_all("R11");
    do_req(2, 16'd1, "R11");
    send_pkt(16'h0003, c, 0);
    do_req(2, 16'd1, "R11");
  endtask

  task automatic t_reopen();
    do_open(0);
    chk_all("R4");
    do_req(0, 16'd1, "R4");
  endtask

  initial begin
    rst = 1'b1; st_valid = 0; st_abort = 0; st_byte = 0;
    open_valid = 0; open_port = 0; req_valid = 0; req_port = 0; req_len = 0;
    exp_rx = '0;
    for (int p = 0; p < 4; p++) begin exp_cr[p] = '0; exp_open[p] = 0; exp_live[p] = 0; end
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_before_open();
    t_open_and_load();
    t_grants();
    t_gaps_and_cap();
    t_abort();
    t_collide_request();
    t_collide_open();
    t_reopen();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 50000);
    checks++; errors++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule